// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block picks the low-power state a microcontroller enters when the CPU executes a stop instruction. It then drives the chip-wide controls for that state: the clock enables per domain, the regulator mode, the pad isolation controls and a one-cycle reset pulse for the module registers. When the stop instruction retires, the CPU raises `stop_req` for one cycle together with the requested stop level. Wake sources are a wake-up timer, a low-frequency receiver detector and an external interrupt. A debug port can send commands while the device is running, stopped or halted for debug.

When debug is enabled, no stop request takes the device into a state that would cut the debug link. A request for the deepest level is redirected to a shallow stop. That stop keeps the debug clock running and the regulator in full regulation. In this stop the debug port still gets answers. Commands that need memory come back with a stop error. A background command wakes the device directly into a halted debug state, where every command is accepted.

The block also holds a small parameter byte bank. The bank has no reset and keeps its contents across every reset and mode. A free-running counter clock enable follows the counter's own enable and halt inputs in every mode.

Top module: `lpstop_ctrl`

## Requirements
- R1: `pm_state` encodes RUN=0, STOP1=1, STOP1_EXIT=2, STOP4=3, STOP4_DBG=4, BACKGROUND=5. Reset puts the block in RUN. In RUN, a `stop_req` in a cycle with no debug command moves the block on the next edge:
  - to STOP4_DBG when `dbg_en`=1, whatever the level;
  - to STOP1 when `dbg_en`=0 and `stop_lvl`=1;
  - to STOP4 when `dbg_en`=0 and any other level (4 or an unlisted value).
- R2: In STOP4_DBG, `ck_en_dbg`=1 and `reg_full`=1. In STOP1 and STOP4, `ck_en_dbg`=0 and `reg_full`=0 (regulator standby).
- R3: In STOP1, STOP4 and STOP4_DBG, `ck_en_sys`=0 and `ck_en_periph`=0. `ck_en_wkup` and `ck_en_lfo` read 1 in every state. In RUN, `ck_en_sys`, `ck_en_periph` and `reg_full` are 1.
- R4: In STOP1, `pad_hiz`=1 and `pad_pu_off`=1. In RUN, STOP4, STOP4_DBG and BACKGROUND, both are 0.
- R5: Any wake event in STOP1 leads to STOP1_EXIT for exactly one cycle. In that cycle `mod_rst`=1 and the pads stay isolated. The next cycle is RUN, with `mod_rst`=0 and the pads released. `pad_hiz` never falls unless `mod_rst` was 1 in the cycle before.
- R6: Any of `wake_wut`, `wake_lfr` or `wake_irq` in STOP4 or STOP4_DBG returns the block to RUN on the next edge. Wake events in RUN have no effect.
- R7: `dbg_cmd` encodes STATUS=0, MEM=1, BKGD=2, GO=3. A command in RUN, STOP4_DBG or BACKGROUND produces one `dbg_rsp_valid` cycle right after the edge that sampled it. A MEM command answers as follows:
  - in STOP4_DBG: `dbg_rsp_ok`=0 and `dbg_rsp_stopped`=1;
  - in RUN or BACKGROUND: `dbg_rsp_ok`=1 and `dbg_rsp_stopped`=0;
  - in STOP1 or STOP4: no response.
- R8: A BKGD command with `dbg_en`=1 in RUN or STOP4_DBG moves the block to BACKGROUND and answers ok=1. In STOP4_DBG it takes priority over a wake event in the same cycle. With `dbg_en`=0 the state does not change and the answer is ok=0.
- R9: In BACKGROUND, every command answers ok=1 and stopped=0. GO returns the block to RUN. `stop_req` is ignored.
- R10: The parameter bank has 64 bytes. It is written when `par_we`=1, read combinationally at `par_addr`, and not cleared by `rst_n`.
- R11: In every state, `ck_en_frc` equals `frc_en` AND NOT `frc_halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low reset |
| dbg_en | input | 1 | Debug-enable bit |
| stop_req | input | 1 | One-cycle stop instruction strobe |
| stop_lvl | input | 3 | Requested stop level (1 deepest, 4 shallow) |
| frc_en | input | 1 | Free-running counter enable |
| frc_halt | input | 1 | Free-running counter halt |
| wake_wut | input | 1 | Wake-up timer event |
| wake_lfr | input | 1 | Low-frequency receiver detector event |
| wake_irq | input | 1 | External interrupt wake |
| dbg_cmd_valid | input | 1 | Debug command strobe |
| dbg_cmd | input | 2 | Debug command code |
| par_we | input | 1 | Parameter bank write enable |
| par_addr | input | 6 | Parameter bank byte address |
| par_wdata | input | 8 | Parameter bank write data |
| ck_en_sys | output | 1 | CPU/system clock enable |
| ck_en_dbg | output | 1 | Debug logic clock enable |
| ck_en_periph | output | 1 | General peripheral clock enable |
| ck_en_wkup | output | 1 | Wake-up timer and LF detector clock enable |
| ck_en_lfo | output | 1 | Low-frequency oscillator enable |
| ck_en_frc | output | 1 | Free-running counter clock enable |
| reg_full | output | 1 | 1 full regulation, 0 standby |
| pad_hiz | output | 1 | Pad buffers disabled |
| pad_pu_off | output | 1 | Pad pull-ups disconnected |
| mod_rst | output | 1 | Module register reset pulse |
| dbg_rsp_valid | output | 1 | Debug response strobe |
| dbg_rsp_ok | output | 1 | Command accepted |
| dbg_rsp_stopped | output | 1 | Command refused because device is stopped |
| pm_state | output | 3 | Current power state code |
| par_rdata | output | 8 | Parameter bank read data |

## Verification
The bench requests the deepest stop with debug enabled. A design that ignores `dbg_en` there would drop into STOP1 and cut the debug clock. It also drives a BKGD command and a wake event in the same cycle. A design with the wrong priority would land in RUN instead of BACKGROUND. The STOP1 exit is sampled cycle by cycle, which catches a reset pulse that is missing or two cycles wide, and pads released before that pulse. Commands sent into STOP1 and STOP4, and a BKGD command with debug disabled, check that no stray response appears and that no unauthorised mode change happens. Finally, the parameter bank is read back after a reset to catch a bank that was wired to the reset.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_STOP1    = 3'd1,
        ST_S1_EXIT  = 3'd2,
        ST_STOP4    = 3'd3,
        ST_STOP4_DBG = 3'd4,
        ST_BKGD     = 3'd5
    } pm_state_e;

    typedef enum logic [1:0] {
        CMD_STATUS = 2'd0,
        CMD_MEM    = 2'd1,
        CMD_BKGD   = 2'd2,
        CMD_GO     = 2'd3
    } dbg_cmd_e;

    typedef struct packed {
        pm_state_e st;
        logic      rst_pulse;
        logic      rsp_v;
        logic      rsp_ok;
        logic      rsp_stop;
    } fsm_regs_t;

    typedef struct packed {
        logic ck_sys;
        logic ck_dbg;
        logic ck_per;
        logic reg_full;
        logic hiz;
        logic pu_off;
    } dom_ctl_t;

endpackage

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
    import lpstop_pkg::*;
#(
    parameter int LVL_W    = 3,
    parameter int LVL_DEEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en,
    input  logic             stop_req,
    input  logic [LVL_W-1:0] stop_lvl,
    input  logic             wake_any,
    input  logic             cmd_v,
    input  dbg_cmd_e         cmd,
    output pm_state_e        state_q,
    output pm_state_e        state_d,
    output logic             rst_pulse,
    output logic             rsp_v,
    output logic             rsp_ok,
    output logic             rsp_stop
);

    localparam logic [LVL_W-1:0] DEEP_CODE = LVL_W'(LVL_DEEP);

    fsm_regs_t r_d, r_q;
    logic      bkgd_go;

    assign bkgd_go = cmd_v && (cmd == CMD_BKGD) && dbg_en;

    always_comb begin
        r_d           = r_q;
        r_d.rst_pulse = 1'b0;
        r_d.rsp_v     = 1'b0;
        r_d.rsp_ok    = 1'b0;
        r_d.rsp_stop  = 1'b0;
        case (r_q.st)
            ST_RUN: begin
                if (cmd_v) begin
                    r_d.rsp_v = 1'b1;
                    case (cmd)
                        CMD_BKGD: begin
                            if (dbg_en) begin
                                r_d.st     = ST_BKGD;
                                r_d.rsp_ok = 1'b1;
                            end
                        end
                        CMD_GO:  r_d.rsp_ok = 1'b0;
                        default: r_d.rsp_ok = 1'b1;
                    endcase
                end else if (stop_req) begin
                    if (dbg_en)
                        r_d.st = ST_STOP4_DBG;
                    else if (stop_lvl == DEEP_CODE)
                        r_d.st = ST_STOP1;
                    else
                        r_d.st = ST_STOP4;
                end
            end
            ST_STOP1: begin
                if (wake_any) begin
                    r_d.st        = ST_S1_EXIT;
                    r_d.rst_pulse = 1'b1;
                end
            end
            ST_S1_EXIT: r_d.st = ST_RUN;
            ST_STOP4: begin
                if (wake_any) r_d.st = ST_RUN;
            end
            ST_STOP4_DBG: begin
                if (cmd_v) begin
                    r_d.rsp_v = 1'b1;
                    if (bkgd_go) r_d.rsp_ok   = 1'b1;
                    else         r_d.rsp_stop = 1'b1;
                end
                if (bkgd_go)       r_d.st = ST_BKGD;
                else if (wake_any) r_d.st = ST_RUN;
            end
            ST_BKGD: begin
                if (cmd_v) begin
                    r_d.rsp_v  = 1'b1;
                    r_d.rsp_ok = 1'b1;
                    if (cmd == CMD_GO) r_d.st = ST_RUN;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q   = r_q.st;
    assign state_d   = r_d.st;
    assign rst_pulse = r_q.rst_pulse;
    assign rsp_v     = r_q.rsp_v;
    assign rsp_ok    = r_q.rsp_ok;
    assign rsp_stop  = r_q.rsp_stop;

    // R1: deepest request under debug is redirected to the debug-keeping stop
    a_r1_debug_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_req && !cmd_v && dbg_en) |=> state_q == ST_STOP4_DBG);

    // R5: module reset pulse is one cycle wide
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    // R6: wake from shallow stop returns to RUN
    a_r6_wake_shallow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP4 && wake_any) |=> state_q == ST_RUN);

    // R7: stopped memory command answers with the stop error
    a_r7_stop_error: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP4_DBG && cmd_v && cmd != CMD_BKGD)
        |=> (rsp_v && !rsp_ok && rsp_stop));

    // R8: background command wins over wake while stopped
    a_r8_bkgd_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP4_DBG && cmd_v && cmd == CMD_BKGD && dbg_en)
        |=> state_q == ST_BKGD);

    // R9: stop request ignored while halted for debug
    a_r9_bkgd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BKGD && !cmd_v) |=> state_q == ST_BKGD);

endmodule

// File: rtl/lpstop_outs.sv
module lpstop_outs
    import lpstop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e st_next,
    input  logic      frc_en,
    input  logic      frc_halt,
    output dom_ctl_t  ctl,
    output logic      ck_wkup,
    output logic      ck_lfo,
    output logic      ck_frc
);

    localparam dom_ctl_t RUN_CTL = '{ck_sys: 1'b1, ck_dbg: 1'b1, ck_per: 1'b1,
                                     reg_full: 1'b1, hiz: 1'b0, pu_off: 1'b0};

    dom_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = RUN_CTL;
        case (st_next)
            ST_STOP1:     ctl_d = '{ck_sys: 1'b0, ck_dbg: 1'b0, ck_per: 1'b0,
                                    reg_full: 1'b0, hiz: 1'b1, pu_off: 1'b1};
            ST_S1_EXIT:   ctl_d = '{ck_sys: 1'b1, ck_dbg: 1'b0, ck_per: 1'b1,
                                    reg_full: 1'b1, hiz: 1'b1, pu_off: 1'b1};
            ST_STOP4:     ctl_d = '{ck_sys: 1'b0, ck_dbg: 1'b0, ck_per: 1'b0,
                                    reg_full: 1'b0, hiz: 1'b0, pu_off: 1'b0};
            ST_STOP4_DBG: ctl_d = '{ck_sys: 1'b0, ck_dbg: 1'b1, ck_per: 1'b0,
                                    reg_full: 1'b1, hiz: 1'b0, pu_off: 1'b0};
            default:      ctl_d = RUN_CTL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= RUN_CTL;
        else        ctl_q <= ctl_d;
    end

    assign ctl     = ctl_q;
    assign ck_wkup = 1'b1;
    assign ck_lfo  = 1'b1;
    assign ck_frc  = frc_en & ~frc_halt;

endmodule

// File: rtl/lpstop_parbank.sv
module lpstop_parbank #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (we && addr == AW'(i)) mem_q[i] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int LVL_W     = 3,
    parameter int LVL_DEEP  = 1,
    parameter int PAR_BYTES = 64,
    parameter int PAR_W     = 8,
    localparam int PAR_AW   = $clog2(PAR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic              stop_req,
    input  logic [LVL_W-1:0]  stop_lvl,
    input  logic              frc_en,
    input  logic              frc_halt,
    input  logic              wake_wut,
    input  logic              wake_lfr,
    input  logic              wake_irq,
    input  logic              dbg_cmd_valid,
    input  logic [1:0]        dbg_cmd,
    input  logic              par_we,
    input  logic [PAR_AW-1:0] par_addr,
    input  logic [PAR_W-1:0]  par_wdata,
    output logic              ck_en_sys,
    output logic              ck_en_dbg,
    output logic              ck_en_periph,
    output logic              ck_en_wkup,
    output logic              ck_en_lfo,
    output logic              ck_en_frc,
    output logic              reg_full,
    output logic              pad_hiz,
    output logic              pad_pu_off,
    output logic              mod_rst,
    output logic              dbg_rsp_valid,
    output logic              dbg_rsp_ok,
    output logic              dbg_rsp_stopped,
    output logic [2:0]        pm_state,
    output logic [PAR_W-1:0]  par_rdata
);

    pm_state_e st_q, st_d;
    dom_ctl_t  ctl;
    logic      wake_any;

    assign wake_any = wake_wut | wake_lfr | wake_irq;

    lpstop_fsm #(.LVL_W(LVL_W), .LVL_DEEP(LVL_DEEP)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_en    (dbg_en),
        .stop_req  (stop_req),
        .stop_lvl  (stop_lvl),
        .wake_any  (wake_any),
        .cmd_v     (dbg_cmd_valid),
        .cmd       (dbg_cmd_e'(dbg_cmd)),
        .state_q   (st_q),
        .state_d   (st_d),
        .rst_pulse (mod_rst),
        .rsp_v     (dbg_rsp_valid),
        .rsp_ok    (dbg_rsp_ok),
        .rsp_stop  (dbg_rsp_stopped)
    );

    lpstop_outs u_outs (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_next  (st_d),
        .frc_en   (frc_en),
        .frc_halt (frc_halt),
        .ctl      (ctl),
        .ck_wkup  (ck_en_wkup),
        .ck_lfo   (ck_en_lfo),
        .ck_frc   (ck_en_frc)
    );

    lpstop_parbank #(.DEPTH(PAR_BYTES), .W(PAR_W)) u_par (
        .clk   (clk),
        .we    (par_we),
        .addr  (par_addr),
        .wdata (par_wdata),
        .rdata (par_rdata)
    );

    assign ck_en_sys    = ctl.ck_sys;
    assign ck_en_dbg    = ctl.ck_dbg;
    assign ck_en_periph = ctl.ck_per;
    assign reg_full     = ctl.reg_full;
    assign pad_hiz      = ctl.hiz;
    assign pad_pu_off   = ctl.pu_off;
    assign pm_state     = st_q;

    // R2: debug stop keeps debug clock and full regulation
    a_r2_dbg_stop_domains: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP4_DBG) |-> (ck_en_dbg && reg_full));

    // R3: no system or peripheral clock in any stop state
    a_r3_periph_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP1 || st_q == ST_STOP4 || st_q == ST_STOP4_DBG)
        |-> (!ck_en_sys && !ck_en_periph));

    // R4: deepest stop isolates the pads
    a_r4_pads_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP1) |-> (pad_hiz && pad_pu_off));

    // R5: pad release only after the module reset pulse
    a_r5_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_hiz) |-> $past(mod_rst));

endmodule

// File: tb/lpstop_ctrl_tb.sv
module lpstop_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbg_en = 0, stop_req = 0, frc_en = 0, frc_halt = 0;
    logic [2:0] stop_lvl = 0;
    logic       wake_wut = 0, wake_lfr = 0, wake_irq = 0;
    logic       dbg_cmd_valid = 0;
    logic [1:0] dbg_cmd = 0;
    logic       par_we = 0;
    logic [5:0] par_addr = 0;
    logic [7:0] par_wdata = 0;
    logic       ck_en_sys, ck_en_dbg, ck_en_periph, ck_en_wkup, ck_en_lfo, ck_en_frc;
    logic       reg_full, pad_hiz, pad_pu_off, mod_rst;
    logic       dbg_rsp_valid, dbg_rsp_ok, dbg_rsp_stopped;
    logic [2:0] pm_state;
    logic [7:0] par_rdata;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_q[$];

    always #4 clk = ~clk;

    lpstop_ctrl u_dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: push expected {ok,stopped} when a response is due
    task automatic cmd(input logic [1:0] c, input bit resp, input bit ok, input bit stp);
        dbg_cmd_valid = 1'b1;
        dbg_cmd = c;
        if (resp) exp_q.push_back({ok, stp});
        tick();
        dbg_cmd_valid = 1'b0;
        tick();
    endtask

    task automatic stop(input logic [2:0] lvl);
        stop_req = 1'b1;
        stop_lvl = lvl;
        tick();
        stop_req = 1'b0;
    endtask

    task automatic wake(input int src);
        wake_wut = (src == 0);
        wake_lfr = (src == 1);
        wake_irq = (src == 2);
        tick();
        {wake_wut, wake_lfr, wake_irq} = '0;
    endtask

    // monitor: compare each response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && dbg_rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected response", {dbg_rsp_ok, dbg_rsp_stopped}, -1);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                eq("R7/R8/R9 response {ok,stopped}", {dbg_rsp_ok, dbg_rsp_stopped}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 R3 R4 reset state
        eq("R1 reset state", pm_state, 0);
        eq("R3 run sys clock", ck_en_sys, 1);
        eq("R3 run periph clock", ck_en_periph, 1);
        eq("R4 run pads", pad_hiz, 0);
        eq("R5 no reset pulse", mod_rst, 0);

        // R10 parameter bank
        par_we = 1; par_addr = 6'd5; par_wdata = 8'hA5; tick();
        par_addr = 6'd63; par_wdata = 8'h3C; tick();
        par_we = 0; par_addr = 6'd5; #1;
        eq("R10 read addr5", par_rdata, 8'hA5);
        par_addr = 6'd63; #1;
        eq("R10 read addr63", par_rdata, 8'h3C);

        // deepest stop without debug
        stop(3'd1);
        eq("R1 stop1 entry", pm_state, 1);
        eq("R4 stop1 hiz", pad_hiz, 1);
        eq("R4 stop1 pullup off", pad_pu_off, 1);
        eq("R3 stop1 periph gated", ck_en_periph, 0);
        eq("R3 stop1 sys gated", ck_en_sys, 0);
        eq("R3 wkup clock on", ck_en_wkup, 1);
        eq("R3 lfo on", ck_en_lfo, 1);
        eq("R2 stop1 dbg clock off", ck_en_dbg, 0);
        eq("R2 stop1 standby", reg_full, 0);
        cmd(2'd1, 0, 0, 0);   // R7 no response in STOP1
        cmd(2'd2, 0, 0, 0);   // R8 no wake without debug
        eq("R8 stop1 unchanged", pm_state, 1);
        wake(0);
        eq("R5 exit state", pm_state, 2);
        eq("R5 reset pulse high", mod_rst, 1);
        eq("R5 pads still isolated", pad_hiz, 1);
        tick();
        eq("R5 back to run", pm_state, 0);
        eq("R5 reset pulse one cycle", mod_rst, 0);
        eq("R5 pads released", pad_hiz, 0);

        // shallow stop
        stop(3'd4);
        eq("R1 stop4 entry", pm_state, 3);
        eq("R2 stop4 standby", reg_full, 0);
        eq("R4 stop4 pads active", pad_hiz, 0);
        cmd(2'd1, 0, 0, 0);   // R7 no response in STOP4
        wake(1);
        eq("R6 lfr wake", pm_state, 0);
        stop(3'd6);
        eq("R1 unlisted level as stop4", pm_state, 3);
        wake(2);
        eq("R6 irq wake", pm_state, 0);
        wake(0);
        eq("R6 wake in run ignored", pm_state, 0);

        // deepest request with debug enabled
        dbg_en = 1;
        stop(3'd1);
        eq("R1 debug redirect", pm_state, 4);
        eq("R2 debug clock kept", ck_en_dbg, 1);
        eq("R2 full regulation", reg_full, 1);
        eq("R3 dbg stop periph gated", ck_en_periph, 0);
        eq("R3 dbg stop sys gated", ck_en_sys, 0);
        eq("R4 dbg stop pads", pad_hiz, 0);
        cmd(2'd1, 1, 0, 1);   // R7 stop error
        eq("R7 still stopped", pm_state, 4);
        wake_wut = 1;
        cmd(2'd2, 1, 1, 0);   // R8 bkgd wins over wake
        wake_wut = 0;
        eq("R8 background entry", pm_state, 5);
        cmd(2'd1, 1, 1, 0);   // R9 mem accepted
        stop(3'd1);
        eq("R9 stop ignored in background", pm_state, 5);
        cmd(2'd3, 1, 1, 0);   // R9 go
        eq("R9 go to run", pm_state, 0);

        cmd(2'd1, 1, 1, 0);   // R7 run mem ok
        cmd(2'd2, 1, 1, 0);
        eq("R8 run to background", pm_state, 5);
        cmd(2'd3, 1, 1, 0);
        dbg_en = 0;
        cmd(2'd2, 1, 0, 0);
        eq("R8 no background without debug", pm_state, 0);

        // R11 counter clock
        frc_en = 1; frc_halt = 0; #1;
        eq("R11 frc on", ck_en_frc, 1);
        frc_halt = 1; #1;
        eq("R11 frc halted", ck_en_frc, 0);
        frc_halt = 0;
        stop(3'd1);
        eq("R11 frc in stop1", ck_en_frc, 1);
        wake(2); tick();

        // R10 survives reset
        rst_n = 0; tick(); rst_n = 1; tick();
        par_addr = 6'd5; #1;
        eq("R10 kept over reset", par_rdata, 8'hA5);
        eq("R7 scoreboard drained", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule